// File: doc/BRIEF.md
# Vector Lane-Wise Logical Right Shifter

This block shifts every element of a wide vector operand right by a constant amount and fills the vacated upper bits with zeros. A single 7-bit packed immediate sets both the element width and the shift amount. The upper four bits form a size field. The position of the highest set bit in that field selects 8, 16, 32 or 64-bit lanes. The shift amount is twice the element width minus the whole 7-bit value. The datapath therefore re-segments itself into lanes of a different width on every operation.

A request is presented with `in_valid`. The result appears one clock later with `out_valid`. Every lane of the result is written; no lane is masked or skipped. A size field of zero is a reserved encoding. It produces a zero result with `out_illegal` raised alongside `out_valid`. The vector length is a compile-time parameter and must be a multiple of 64.

Top module: `vshr_top`

## Requirements
- R1: The lane width is decoded from the size field `size_sel`: 0001 selects 8 bits, 001x selects 16 bits, 01xx selects 32 bits and 1xxx selects 64 bits.
- R2: The shift amount is 2*width minus the unsigned 7-bit value {size_sel, imm_lo}. For every legal encoding this amount lies in 1..width.
- R3: Each lane is shifted right with zeros entering from its top. No bit moves from one lane into its neighbour.
- R4: When the shift amount equals the lane width, that lane's result is all zeros.
- R5: All VLEN/width lanes are written. Lane e occupies bits [e*width +: width] of both the operand and the result.
- R6: A size field of 0000 raises `out_illegal` in the same cycle as `out_valid`, and `out_result` is zero in that cycle.
- R7: `out_valid` equals `in_valid` delayed by exactly one clock, and the result belongs to the request sampled at that edge. Back-to-back requests produce back-to-back results.
- R8: In any cycle where `out_valid` is low, `out_result` is zero and `out_illegal` is low.
- R9: While `rst_n` is low, `out_valid`, `out_illegal` and `out_result` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| operand | input | VLEN | Source vector |
| size_sel | input | 4 | Size field; the upper part of the packed immediate |
| imm_lo | input | 3 | Low three bits of the packed immediate |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_result | output | VLEN | Shifted vector |
| out_illegal | output | 1 | Reserved size encoding seen |

## Verification
The lane-width decode and the shift-amount arithmetic are both applied in the same cycle to the same immediate. An error in either one corrupts every lane. The bench sweeps all 128 values of the 7-bit immediate back to back, with random operands and an all-ones operand. Each result is compared bit by bit against a reference that recomputes the width and the amount arithmetically. The all-ones operand makes a full-width shift or a bit leaking across a lane boundary show up directly. The reserved encodings are mixed into the same sweep, so the illegal flag and a following legal result are judged on adjacent cycles.

// File: rtl/vshr_pkg.sv
package vshr_pkg;

    localparam int SIZE_W   = 4;
    localparam int IMM_W    = 3;
    localparam int PACK_W   = SIZE_W + IMM_W;
    localparam int N_WIDTHS = 4;
    localparam int BASE_W   = 8;

    typedef enum logic [1:0] {
        LW_8  = 2'd0,
        LW_16 = 2'd1,
        LW_32 = 2'd2,
        LW_64 = 2'd3
    } lane_w_e;

endpackage

// File: rtl/vshr_decode.sv
module vshr_decode
    import vshr_pkg::*;
(
    input  logic [SIZE_W-1:0] size_sel,
    input  logic [IMM_W-1:0]  imm_lo,
    output lane_w_e           lane_w,
    output logic [6:0]        shamt,
    output logic              illegal
);

    logic [1:0] top_bit;
    logic [7:0] twice_w;
    logic [7:0] diff;

    always_comb begin
        if (size_sel[3])      top_bit = 2'd3;
        else if (size_sel[2]) top_bit = 2'd2;
        else if (size_sel[1]) top_bit = 2'd1;
        else                  top_bit = 2'd0;
    end

    assign illegal = (size_sel == '0);
    assign lane_w  = lane_w_e'(top_bit);
    assign twice_w = 8'(2 * BASE_W) << top_bit;
    assign diff    = twice_w - {1'b0, size_sel, imm_lo};
    assign shamt   = diff[6:0];

endmodule

// File: rtl/vshr_lanes.sv
module vshr_lanes #(
    parameter int VLEN  = 128,
    parameter int ESIZE = 8
) (
    input  logic [VLEN-1:0] vec_in,
    input  logic [6:0]      shamt,
    output logic [VLEN-1:0] vec_out
);

    localparam int LANES = VLEN / ESIZE;

    for (genvar e = 0; e < LANES; e++) begin : g_lane
        logic [ESIZE-1:0] elem;
        assign elem = vec_in[e*ESIZE +: ESIZE];
        assign vec_out[e*ESIZE +: ESIZE] = elem >> shamt;
    end

endmodule

// File: rtl/vshr_top.sv
module vshr_top
    import vshr_pkg::*;
#(
    parameter int VLEN = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [VLEN-1:0]   operand,
    input  logic [SIZE_W-1:0] size_sel,
    input  logic [IMM_W-1:0]  imm_lo,
    output logic              out_valid,
    output logic [VLEN-1:0]   out_result,
    output logic              out_illegal
);

    typedef struct packed {
        logic            valid;
        logic            illegal;
        logic [VLEN-1:0] result;
    } stage_t;

    stage_t st_d, st_q;

    lane_w_e    lane_w;
    logic [6:0] shamt;
    logic       dec_illegal;

    logic [VLEN-1:0] width_res [N_WIDTHS];

    vshr_decode u_dec (
        .size_sel (size_sel),
        .imm_lo   (imm_lo),
        .lane_w   (lane_w),
        .shamt    (shamt),
        .illegal  (dec_illegal)
    );

    for (genvar k = 0; k < N_WIDTHS; k++) begin : g_width
        vshr_lanes #(
            .VLEN  (VLEN),
            .ESIZE (BASE_W << k)
        ) u_lanes (
            .vec_in  (operand),
            .shamt   (shamt),
            .vec_out (width_res[k])
        );
    end

    always_comb begin
        st_d = '0;
        if (in_valid) begin
            st_d.valid   = 1'b1;
            st_d.illegal = dec_illegal;
            if (!dec_illegal) begin
                st_d.result = width_res[lane_w];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid   = st_q.valid;
    assign out_illegal = st_q.illegal;
    assign out_result  = st_q.result;

endmodule

// File: rtl/vshr_checker.sv
module vshr_checker #(
    parameter int VLEN = 128
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [3:0]      size_sel,
    input logic            out_valid,
    input logic [VLEN-1:0] out_result,
    input logic            out_illegal
);

    assert_valid_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_no_spurious_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_reserved_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && size_sel == 4'd0) |=> (out_illegal && out_valid));

    assert_reserved_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_illegal |-> (out_result == '0));

    assert_legal_no_flag_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && size_sel != 4'd0) |=> !out_illegal);

    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_result == '0 && !out_illegal));

    always_comb begin
        if (!rst_n) begin
            assert_reset_state_R9: assert (!out_valid && !out_illegal && out_result == '0);
        end
    end

endmodule

bind vshr_top vshr_checker #(.VLEN(VLEN)) u_vshr_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .size_sel    (size_sel),
    .out_valid   (out_valid),
    .out_result  (out_result),
    .out_illegal (out_illegal)
);

// File: tb/tb_vshr_top.sv
module tb_vshr_top;

    localparam int VLEN     = 128;
    localparam int CLK_PER  = 10;
    localparam int WATCHDOG = 200000;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            in_valid;
    logic [VLEN-1:0] operand;
    logic [3:0]      size_sel;
    logic [2:0]      imm_lo;
    logic            out_valid;
    logic [VLEN-1:0] out_result;
    logic            out_illegal;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #(CLK_PER/2) clk = ~clk;

    vshr_top #(.VLEN(VLEN)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .operand     (operand),
        .size_sel    (size_sel),
        .imm_lo      (imm_lo),
        .out_valid   (out_valid),
        .out_result  (out_result),
        .out_illegal (out_illegal)
    );

    function automatic int width_of(input logic [3:0] sz);
        if (sz[3])      return 64;
        else if (sz[2]) return 32;
        else if (sz[1]) return 16;
        else            return 8;
    endfunction

    function automatic int amount_of(input logic [3:0] sz, input logic [2:0] im);
        return 2 * width_of(sz) - int'({sz, im});
    endfunction

    function automatic logic [VLEN-1:0] ref_shift(input logic [VLEN-1:0] v,
                                                   input logic [3:0] sz,
                                                   input logic [2:0] im);
        logic [VLEN-1:0] r;
        int w;
        int sh;
        r  = '0;
        if (sz == 4'd0) return r;
        w  = width_of(sz);
        sh = amount_of(sz, im);
        for (int b = 0; b < VLEN; b++) begin
            int lane;
            int pos;
            lane = b / w;
            pos  = b % w;
            if (pos + sh < w) r[b] = v[lane*w + pos + sh];
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [VLEN-1:0] act,
                         input logic [VLEN-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [VLEN-1:0] rand_vec();
        logic [VLEN-1:0] v;
        for (int i = 0; i < VLEN / 32; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    task automatic issue(input logic [VLEN-1:0] v, input logic [3:0] sz,
                         input logic [2:0] im, input string req);
        logic [VLEN-1:0] exp;
        in_valid = 1'b1;
        operand  = v;
        size_sel = sz;
        imm_lo   = im;
        exp      = ref_shift(v, sz, im);
        @(negedge clk);
        check({req, " valid"}, VLEN'(out_valid), VLEN'(1));
        check({req, " flag"}, VLEN'(out_illegal), VLEN'(sz == 4'd0));
        check({req, " result"}, out_result, exp);
    endtask

    initial begin
        rst_n    = 1'b0;
        in_valid = 1'b0;
        operand  = '1;
        size_sel = 4'd1;
        imm_lo   = 3'd0;
        repeat (3) @(negedge clk);
        // R9: outputs are quiet while reset is held
        check("R9 valid", VLEN'(out_valid), '0);
        check("R9 flag", VLEN'(out_illegal), '0);
        check("R9 result", out_result, '0);
        rst_n = 1'b1;
        @(negedge clk);
        // R8: no request means no result, even with inputs wiggling
        check("R8 idle result", out_result, '0);
        check("R8 idle valid", VLEN'(out_valid), '0);

        // R1 R2 R3 R5 R6 R7: full sweep of the 7-bit immediate, back to back
        for (int p = 0; p < 128; p++) begin
            logic [6:0] pk;
            pk = 7'(p);
            issue('1, pk[6:3], pk[2:0], "R3 R4 ones sweep");
            for (int k = 0; k < 4; k++) begin
                issue(rand_vec(), pk[6:3], pk[2:0], "R1 R2 R5 random sweep");
            end
        end

        // R4: full-width shift clears each lane, for every width
        issue('1, 4'b0001, 3'b000, "R4 w8 full");
        issue('1, 4'b0010, 3'b000, "R4 w16 full");
        issue('1, 4'b0100, 3'b000, "R4 w32 full");
        issue('1, 4'b1000, 3'b000, "R4 w64 full");
        // R2: shift by one keeps all but the lowest bit of each lane
        issue('1, 4'b1111, 3'b111, "R2 shift1 w64");
        issue('1, 4'b0001, 3'b111, "R2 shift1 w8");
        // R3: a marker in the lowest bit of a lane must not show up in the lane below
        issue({{(VLEN-9){1'b0}}, 1'b1, 8'h00}, 4'b0001, 3'b111, "R3 no borrow");

        // R6 then a legal request on the next cycle
        issue(rand_vec(), 4'b0000, 3'b101, "R6 reserved");
        issue('1, 4'b0011, 3'b000, "R6 recovery");

        // R7 R8: drop valid, output must go quiet one cycle later
        in_valid = 1'b0;
        operand  = '1;
        @(negedge clk);
        check("R7 drop valid", VLEN'(out_valid), '0);
        check("R8 drop result", out_result, '0);
        check("R8 drop flag", VLEN'(out_illegal), '0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule